// File: doc/BRIEF.md
# Hardware Fault Retry Controller

This block decides the processor's response when a memory, processor or interface unit reports a parity or sequence-check fault while an instruction is executing. Before any trap is taken, it asks the execution pipeline to run the faulting instruction one more time. If that single retry completes cleanly, execution goes on with the next instruction. The block then pulses a processor-fault interrupt and sets a sticky status bit that records the successful retry. If the retry fails, or if it is not allowed, the block requests the hardware-error trap. The trap vector is fixed, and the trap condition code shows whether the fault was a register-file parity error.

A retry is not allowed in three cases: the instruction is itself running as a trap or interrupt entry instruction, the register-altered flag of the current status words is set, or the retry-inhibit bit of the processor control register is set. These three inhibit inputs are sampled in the cycle the fault is first reported. The controller does not re-execute anything itself. It only issues requests, and the surrounding pipeline reports back how the retry ended.

Top module: `hw_fault_retry_ctl`

## Requirements
- R1: After reset, retry_req_o, trap_req_o, pfi_o and retry_ok_o are 0, and trap_addr_o and trap_cc_o are 0.
- R2: A fault reported while idle, with all three inhibit inputs at 0, raises retry_req_o in the following cycle for exactly one cycle.
- R3: A fault reported while idle with in_trap_seq_i=1 produces trap_req_o in the following cycle and no retry_req_o.
- R4: A fault reported while idle with regs_altered_i=1 produces trap_req_o in the following cycle and no retry_req_o.
- R5: A fault reported while idle with retry_inhibit_i=1 produces trap_req_o in the following cycle and no retry_req_o.
- R6: When the retry ends with retry_done_i=1 and retry_pass_i=1, the next cycle has a one-cycle pfi_o pulse, retry_ok_o=1 and no trap. A retry_done_i seen while idle has no effect.
- R7: When the retry ends with retry_done_i=1 and retry_pass_i=0, trap_req_o is asserted in the following cycle.
- R8: A new fault reported while a retry is requested or outstanding counts as a failed retry: trap_req_o follows in the next cycle, even if retry_done_i and retry_pass_i are 1 in that same cycle.
- R9: While trap_req_o is 1, trap_addr_o equals 0x4C.
- R10: While trap_req_o is 1, trap_cc_o is 4'b0000 if the most recently reported fault had reg_parity_i=1, and 4'b0001 otherwise.
- R11: retry_ok_o stays 1 until status_clr_i is sampled at 1, and reads 0 the cycle after that. A successful retry in the same cycle as a clear wins, so the bit stays 1.
- R12: trap_req_o lasts exactly one cycle, and the controller then returns to idle. A fault reported during that trap cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fault_i | input | 1 | One-cycle report of a hardware fault |
| reg_parity_i | input | 1 | With fault_i: the fault is a general- or control-register parity error |
| in_trap_seq_i | input | 1 | The current instruction runs as a trap/interrupt instruction |
| regs_altered_i | input | 1 | Register-altered flag of the current status words |
| retry_inhibit_i | input | 1 | Retry-inhibit bit of the processor control register |
| retry_done_i | input | 1 | Retry outcome is valid this cycle |
| retry_pass_i | input | 1 | With retry_done_i: the retry completed without fault |
| status_clr_i | input | 1 | Clears the sticky retry-succeeded bit |
| retry_req_o | output | 1 | One-cycle request to re-execute the current instruction |
| trap_req_o | output | 1 | One-cycle hardware-error trap request |
| trap_addr_o | output | 8 | Trap location, valid with trap_req_o |
| trap_cc_o | output | 4 | Trap condition code, valid with trap_req_o |
| pfi_o | output | 1 | One-cycle processor-fault interrupt after a successful retry |
| retry_ok_o | output | 1 | Sticky retry-succeeded status bit |

## Verification
The embedded properties check the following on every cycle:
- each kind of inhibit leads to a trap with no retry;
- retry and trap requests last only one cycle;
- a fault during an outstanding retry turns into a trap;
- the interrupt pulse never comes together with a trap and always comes with the sticky bit set;
- the sticky bit holds until it is cleared.

Only the directed scenarios can show the following:
- the exact trap address and the condition-code values for each fault class;
- the order of events across a full retry;
- that retry outcomes reported while idle, and faults reported during the trap cycle, leave no trace;
- that a successful retry wins over a clear arriving in the same cycle.

// File: rtl/fault_retry_pkg.sv
package fault_retry_pkg;

  typedef enum logic [1:0] {
    RC_IDLE  = 2'd0,
    RC_RETRY = 2'd1,
    RC_WAIT  = 2'd2,
    RC_TRAP  = 2'd3
  } rc_state_e;

endpackage

// File: rtl/fault_classifier.sv
module fault_classifier #(
  parameter int CC_W = 4,
  parameter logic [CC_W-1:0] CC_GENERAL = 4'b0001,
  parameter logic [CC_W-1:0] CC_REGPAR  = 4'b0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture_i,
  input  logic            reg_parity_i,
  input  logic            in_trap_seq_i,
  input  logic            regs_altered_i,
  input  logic            retry_inhibit_i,
  output logic            inhibit_o,
  output logic [CC_W-1:0] cc_o
);

  logic par_q, par_d;

  // Any of the three conditions forbids a retry.
  always_comb begin
    inhibit_o = in_trap_seq_i | regs_altered_i | retry_inhibit_i;
  end

  // The class of the most recent accepted fault is held for the trap code.
  always_comb begin
    par_d = par_q;
    if (capture_i) par_d = reg_parity_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= 1'b0;
    else        par_q <= par_d;
  end

  always_comb begin
    cc_o = par_q ? CC_REGPAR : CC_GENERAL;
  end

endmodule

// File: rtl/retry_fsm.sv
module retry_fsm
  import fault_retry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic inhibit_i,
  input  logic done_i,
  input  logic pass_i,
  output logic capture_o,
  output logic success_o,
  output logic retry_req_o,
  output logic trap_req_o
);

  rc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RC_IDLE: begin
        if (fault_i) state_d = inhibit_i ? RC_TRAP : RC_RETRY;
      end
      RC_RETRY: begin
        state_d = fault_i ? RC_TRAP : RC_WAIT;
      end
      RC_WAIT: begin
        if (fault_i)                state_d = RC_TRAP;
        else if (done_i && pass_i)  state_d = RC_IDLE;
        else if (done_i)            state_d = RC_TRAP;
      end
      RC_TRAP: begin
        state_d = RC_IDLE;
      end
      default: state_d = RC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RC_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    capture_o   = fault_i && (state_q != RC_TRAP);
    success_o   = (state_q == RC_WAIT) && done_i && pass_i && !fault_i;
    retry_req_o = (state_q == RC_RETRY);
    trap_req_o  = (state_q == RC_TRAP);
  end

  // R2: a retry request lasts one cycle
  p_retry_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req_o |=> !retry_req_o);

  // R3 / R4 / R5: any inhibit sends an idle fault straight to the trap
  p_inhibit_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RC_IDLE && fault_i && inhibit_i) |=> (trap_req_o && !retry_req_o));

  // R8: a fault while a retry is outstanding becomes a trap
  p_wait_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == RC_WAIT || state_q == RC_RETRY) && fault_i) |=> trap_req_o);

  // R7: a failed retry traps
  p_fail_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RC_WAIT && done_i && !pass_i) |=> trap_req_o);

  // R12: a trap request lasts one cycle and is followed by idle
  p_trap_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o |=> (!trap_req_o && !retry_req_o));

endmodule

// File: rtl/retry_status.sv
module retry_status (
  input  logic clk,
  input  logic rst_n,
  input  logic success_i,
  input  logic clr_i,
  output logic pfi_o,
  output logic sticky_o
);

  logic pfi_d, sticky_d;

  always_comb begin
    pfi_d    = success_i;
    sticky_d = sticky_o;
    if (clr_i)     sticky_d = 1'b0;
    if (success_i) sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfi_o    <= 1'b0;
      sticky_o <= 1'b0;
    end else begin
      pfi_o    <= pfi_d;
      sticky_o <= sticky_d;
    end
  end

  // R11: the status bit holds until cleared
  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_o && !clr_i) |=> sticky_o);

  // R6: the interrupt is a single-cycle pulse
  p_pfi_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pfi_o |=> !pfi_o);

endmodule

// File: rtl/hw_fault_retry_ctl.sv
module hw_fault_retry_ctl #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] TRAP_VEC = 8'h4C,
  parameter int CC_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_i,
  input  logic              reg_parity_i,
  input  logic              in_trap_seq_i,
  input  logic              regs_altered_i,
  input  logic              retry_inhibit_i,
  input  logic              retry_done_i,
  input  logic              retry_pass_i,
  input  logic              status_clr_i,
  output logic              retry_req_o,
  output logic              trap_req_o,
  output logic [ADDR_W-1:0] trap_addr_o,
  output logic [CC_W-1:0]   trap_cc_o,
  output logic              pfi_o,
  output logic              retry_ok_o
);

  localparam logic [CC_W-1:0] CC_GEN = CC_W'(1);
  localparam logic [CC_W-1:0] CC_PAR = '0;

  // Asynchronous assertion, synchronous release.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  logic            inhibit, capture, success;
  logic [CC_W-1:0] cc_held;

  fault_classifier #(
    .CC_W       (CC_W),
    .CC_GENERAL (CC_GEN),
    .CC_REGPAR  (CC_PAR)
  ) u_class (
    .clk             (clk),
    .rst_n           (rst_n_int),
    .capture_i       (capture),
    .reg_parity_i    (reg_parity_i),
    .in_trap_seq_i   (in_trap_seq_i),
    .regs_altered_i  (regs_altered_i),
    .retry_inhibit_i (retry_inhibit_i),
    .inhibit_o       (inhibit),
    .cc_o            (cc_held)
  );

  retry_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .fault_i     (fault_i),
    .inhibit_i   (inhibit),
    .done_i      (retry_done_i),
    .pass_i      (retry_pass_i),
    .capture_o   (capture),
    .success_o   (success),
    .retry_req_o (retry_req_o),
    .trap_req_o  (trap_req_o)
  );

  retry_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .success_i (success),
    .clr_i     (status_clr_i),
    .pfi_o     (pfi_o),
    .sticky_o  (retry_ok_o)
  );

  always_comb begin
    trap_addr_o = trap_req_o ? TRAP_VEC : '0;
    trap_cc_o   = trap_req_o ? cc_held  : '0;
  end

  // R6: an interrupt after a retry never comes with a trap and always with status set
  p_pfi_no_trap_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    pfi_o |-> (!trap_req_o && retry_ok_o));

  // R1: request outputs are quiet while held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_int |-> (!retry_req_o && !trap_req_o && !pfi_o));

endmodule

// File: tb/test_hw_fault_retry_ctl.sv
`timescale 1ns/1ps
module test_hw_fault_retry_ctl;

  logic clk = 1'b0;
  logic rst_n;
  logic fault_i, reg_parity_i, in_trap_seq_i, regs_altered_i, retry_inhibit_i;
  logic retry_done_i, retry_pass_i, status_clr_i;
  logic retry_req_o, trap_req_o, pfi_o, retry_ok_o;
  logic [7:0] trap_addr_o;
  logic [3:0] trap_cc_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  hw_fault_retry_ctl i_hw_fault_retry_ctl (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .reg_parity_i(reg_parity_i),
    .in_trap_seq_i(in_trap_seq_i), .regs_altered_i(regs_altered_i),
    .retry_inhibit_i(retry_inhibit_i), .retry_done_i(retry_done_i),
    .retry_pass_i(retry_pass_i), .status_clr_i(status_clr_i),
    .retry_req_o(retry_req_o), .trap_req_o(trap_req_o), .trap_addr_o(trap_addr_o),
    .trap_cc_o(trap_cc_o), .pfi_o(pfi_o), .retry_ok_o(retry_ok_o)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    fault_i = 0; reg_parity_i = 0; in_trap_seq_i = 0; regs_altered_i = 0;
    retry_inhibit_i = 0; retry_done_i = 0; retry_pass_i = 0; status_clr_i = 0;
  endtask

  // inputs set after a falling edge are sampled at the next rising edge;
  // results are read at the following falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    chk("R1 retry_req", retry_req_o, 0);
    chk("R1 trap_req", trap_req_o, 0);
    chk("R1 pfi", pfi_o, 0);
    chk("R1 retry_ok", retry_ok_o, 0);
    chk("R1 trap_addr", trap_addr_o, 0);
    chk("R1 trap_cc", trap_cc_o, 0);
  endtask

  task automatic t_idle_done_ignored();
    retry_done_i = 1; retry_pass_i = 1; tick();
    chk("R6 idle done pfi", pfi_o, 0);
    chk("R6 idle done ok", retry_ok_o, 0);
  endtask

  task automatic t_retry_success();
    fault_i = 1; tick();
    chk("R2 retry_req raised", retry_req_o, 1);
    chk("R2 no trap", trap_req_o, 0);
    tick();
    chk("R2 retry_req one cycle", retry_req_o, 0);
    retry_done_i = 1; retry_pass_i = 1; tick();
    chk("R6 pfi pulse", pfi_o, 1);
    chk("R6 retry_ok set", retry_ok_o, 1);
    chk("R6 no trap", trap_req_o, 0);
    tick();
    chk("R6 pfi ends", pfi_o, 0);
    chk("R11 retry_ok holds", retry_ok_o, 1);
  endtask

  task automatic t_retry_fail();
    fault_i = 1; reg_parity_i = 1; tick();
    chk("R2 retry_req", retry_req_o, 1);
    tick();
    retry_done_i = 1; retry_pass_i = 0; tick();
    chk("R7 trap after failed retry", trap_req_o, 1);
    chk("R9 trap addr", trap_addr_o, 32'h4C);
    chk("R10 cc register parity", trap_cc_o, 4'b0000);
    chk("R7 no pfi", pfi_o, 0);
    tick();
    chk("R12 trap one cycle", trap_req_o, 0);
  endtask

  task automatic t_inhibit(input int kind, input string tag);
    fault_i = 1;
    case (kind)
      0: in_trap_seq_i = 1;
      1: regs_altered_i = 1;
      default: retry_inhibit_i = 1;
    endcase
    tick();
    chk({tag, " trap"}, trap_req_o, 1);
    chk({tag, " no retry"}, retry_req_o, 0);
    chk("R10 cc general", trap_cc_o, 4'b0001);
    chk("R9 trap addr", trap_addr_o, 32'h4C);
    tick();
    chk("R12 trap ends", trap_req_o, 0);
    chk({tag, " still no retry"}, retry_req_o, 0);
  endtask

  task automatic t_fault_in_wait();
    fault_i = 1; reg_parity_i = 1; tick();
    tick();
    fault_i = 1; reg_parity_i = 0; retry_done_i = 1; retry_pass_i = 1; tick();
    chk("R8 fault in wait traps", trap_req_o, 1);
    chk("R8 no pfi", pfi_o, 0);
    chk("R10 cc follows latest fault", trap_cc_o, 4'b0001);
    tick();
  endtask

  task automatic t_fault_in_retry();
    fault_i = 1; tick();
    chk("R2 retry_req", retry_req_o, 1);
    fault_i = 1; reg_parity_i = 1; tick();
    chk("R8 fault in retry traps", trap_req_o, 1);
    chk("R10 cc register parity", trap_cc_o, 4'b0000);
    tick();
  endtask

  task automatic t_fault_in_trap();
    fault_i = 1; retry_inhibit_i = 1; tick();
    chk("R5 trap", trap_req_o, 1);
    fault_i = 1; reg_parity_i = 1; tick();
    chk("R12 back to idle", trap_req_o, 0);
    chk("R12 fault in trap ignored", retry_req_o, 0);
    tick();
    chk("R12 no later trap", trap_req_o, 0);
    chk("R12 no later retry", retry_req_o, 0);
  endtask

  task automatic t_sticky_clear();
    status_clr_i = 1; tick();
    chk("R11 cleared", retry_ok_o, 0);
    fault_i = 1; tick();
    tick();
    retry_done_i = 1; retry_pass_i = 1; status_clr_i = 1; tick();
    chk("R11 set beats clear", retry_ok_o, 1);
    chk("R6 pfi", pfi_o, 1);
    status_clr_i = 1; tick();
    chk("R11 cleared again", retry_ok_o, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle_done_ignored();
    t_retry_success();
    t_retry_fail();
    t_inhibit(0, "R3");
    t_inhibit(1, "R4");
    t_inhibit(2, "R5");
    t_fault_in_wait();
    t_fault_in_retry();
    t_fault_in_trap();
    t_sticky_clear();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule